// File: doc/BRIEF.md
# Overlapping multi-bank DRAM strobe sequencer

This block drives row and column strobes for a DRAM array split into banks. The upper address bits select the bank. A host opens an access with a start edge and a chip select, and holds it open with a hold request. The controller puts the row half of the address on a shared multiplexed bus and raises that bank's RAS. On the next edge it switches the bus to the column half and raises CAS. CAS then stays up until the host lets go of the hold request.

When overlap is enabled, the access moves to a parked state once CAS has been held for the column hold time. The bus then goes back to a row address, and a waiting access to a different bank can open while the parked access still holds its strobes. When overlap is disabled, or when a page-type access mode is selected, the column value stays on the bus. In that case the next access waits for the current one to close.

A bank that has just closed, or any bank after a refresh, must wait out a precharge count before it is opened again. Two host start styles are supported. In the pulse style the start edge is valid only after the hold request has been seen. In the level style the strobe must have been low for a minimum number of cycles. A start edge that breaks its style's timing is flagged and dropped.

Top module: `dram_pipe_ctrl`

## Requirements
- R1: During and straight after reset every RAS, CAS and write enable output is low, the multiplexed address is 0, and `host_wait`, `host_ack` and `proto_err` are low.
- R2: A start accepted on clock edge n opens its bank on edge n+1: RAS goes high and the row field (address bits [2*MUX_W-1:MUX_W]) appears on `dram_addr`. On edge n+2 the column field (bits [MUX_W-1:0]) appears and CAS goes high. CAS is never high on a bank whose RAS is low.
- R3: With overlap in effect, the access parks T_COLH edges after CAS rises. RAS and CAS stay high and `dram_addr` returns to a row: that of the waiting access, or its own row if none is waiting. A waiting access to another bank opens on the next edge.
- R4: With `cfg_pipe` low, or with `cfg_page` high, a parked access keeps its column value on `dram_addr`, and no other access opens until it closes.
- R5: While an access is parked, a low `host_hold` sampled on an edge drops that bank's RAS, CAS and write enable on that edge.
- R6: A closed bank is reopened no earlier than T_PRE+1 edges after the edge that closed it.
- R7: `refresh_req` blocks any access from opening. Each edge on which it is sampled high with no open access reloads the precharge count of every bank, so a waiting access opens T_PRE+1 edges after the last such edge.
- R8: With `cfg_mode` = 0 (pulse style), a start edge is accepted only if `host_hold` has been sampled high on an edge since the last accepted start. An earlier edge raises `proto_err` in that cycle and opens no access.
- R9: With `cfg_mode` = 1 (level style), a start edge is accepted only after the strobe has been sampled low on at least T_NEG edges since the last accepted start. An earlier edge raises `proto_err` and opens no access.
- R10: `host_ack` is high when `cfg_ack_en` is set, an access is parked and `host_hold` is high. It falls in the same cycle that `host_hold` falls.
- R11: `host_wait` is high when `cfg_wait_en` is set and a start is being accepted this cycle, an accepted access has not yet opened, or an opened access has not yet parked.
- R12: A start edge with `host_cs` low is ignored: no error and no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_pipe | input | 1 | Overlap enable |
| cfg_page | input | 1 | Page-type access mode selected; disables overlap |
| cfg_mode | input | 1 | 0 = pulse start style, 1 = level strobe style |
| cfg_wait_en | input | 1 | Enables `host_wait` |
| cfg_ack_en | input | 1 | Enables `host_ack` |
| host_start | input | 1 | Latch pulse or address strobe |
| host_cs | input | 1 | Chip select, sampled with the start edge |
| host_hold | input | 1 | Keeps the parked access open |
| host_we | input | 1 | Write flag of the access |
| host_addr | input | BANK_W+2*MUX_W | Bank, row and column fields |
| refresh_req | input | 1 | Refresh request; forces precharge |
| host_wait | output | 1 | Wait indication to host |
| host_ack | output | 1 | Transfer acknowledge |
| proto_err | output | 1 | Start edge rejected by timing rule |
| dram_addr | output | MUX_W | Multiplexed row/column address |
| dram_ras | output | 2**BANK_W | Per-bank row strobe, active high |
| dram_cas | output | 2**BANK_W | Per-bank column strobe, active high |
| dram_we | output | 2**BANK_W | Per-bank write enable, active high |

## Verification
A table runs one pair of accesses under seven settings: overlap on or off, page mode set, pulse or level start style, and second access to the same or a different bank. The cycle on which the second bank opens then shows whether overlap, wait-for-close or a precharge delay applied. The bus value at the park edge shows the row-return rule. Directed cases cover a refresh holding off a waiting access, early start edges in each style, a deselected start, and both handshake outputs disabled.

// File: rtl/dram_pipe_ctrl.sv
module dram_pipe_ctrl #(
  parameter int BANK_W = 2,
  parameter int MUX_W  = 6,
  parameter int T_COLH = 2,
  parameter int T_PRE  = 3,
  parameter int T_NEG  = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_pipe,
  input  logic                          cfg_page,
  input  logic                          cfg_mode,
  input  logic                          cfg_wait_en,
  input  logic                          cfg_ack_en,
  input  logic                          host_start,
  input  logic                          host_cs,
  input  logic                          host_hold,
  input  logic                          host_we,
  input  logic [BANK_W+2*MUX_W-1:0]     host_addr,
  input  logic                          refresh_req,
  output logic                          host_wait,
  output logic                          host_ack,
  output logic                          proto_err,
  output logic [MUX_W-1:0]              dram_addr,
  output logic [(1<<BANK_W)-1:0]        dram_ras,
  output logic [(1<<BANK_W)-1:0]        dram_cas,
  output logic [(1<<BANK_W)-1:0]        dram_we
);
  localparam int NB  = 1 << BANK_W;
  localparam int AW  = BANK_W + 2*MUX_W;
  localparam int CHW = $clog2(T_COLH + 1);
  localparam int PRW = $clog2(T_PRE + 1);
  localparam int NGW = $clog2(T_NEG + 1);

  logic              start_q, hold_ok;
  logic [NGW-1:0]    neg_cnt;
  logic              pend_v, pend_we;
  logic [AW-1:0]     pend_addr;
  logic              front_v, front_ph;
  logic [BANK_W-1:0] front_bank, park_bank;
  logic [AW-1:0]     front_addr;
  logic [CHW-1:0]    hcnt;
  logic              park_v;
  logic [PRW-1:0]    pre_cnt [NB];

  wire               pipe_eff = cfg_pipe & ~cfg_page;
  wire               rise     = host_start & ~start_q;
  wire               tim_ok   = cfg_mode ? (neg_cnt >= NGW'(T_NEG)) : hold_ok;
  wire               accept   = rise & host_cs & tim_ok & ~pend_v;
  wire [BANK_W-1:0]  pb       = pend_addr[AW-1 -: BANK_W];
  wire               closing  = park_v & ~host_hold;
  wire               launch   = pend_v & ~refresh_req & ~front_v & (pipe_eff | ~park_v)
                                & ~dram_ras[pb] & (pre_cnt[pb] == '0);
  wire               park_now = front_v & front_ph & (hcnt == CHW'(1)) & (~park_v | closing);
  wire               ref_go   = refresh_req & ~front_v & ~park_v;

  assign proto_err = rise & host_cs & ~(tim_ok & ~pend_v);
  assign host_wait = cfg_wait_en & (accept | pend_v | front_v);
  assign host_ack  = cfg_ack_en & park_v & host_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      hold_ok <= 1'b1;
      neg_cnt <= NGW'(T_NEG);
    end else begin
      start_q <= host_start;
      if (accept)                                  hold_ok <= 1'b0;
      else if (host_hold)                          hold_ok <= 1'b1;
      if (accept)                                  neg_cnt <= '0;
      else if (!host_start && neg_cnt < NGW'(T_NEG)) neg_cnt <= neg_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v     <= 1'b0;
      pend_we    <= 1'b0;
      pend_addr  <= '0;
      front_v    <= 1'b0;
      front_ph   <= 1'b0;
      front_bank <= '0;
      front_addr <= '0;
      hcnt       <= '0;
      park_v     <= 1'b0;
      park_bank  <= '0;
      dram_addr  <= '0;
      dram_ras   <= '0;
      dram_cas   <= '0;
      dram_we    <= '0;
      for (int i = 0; i < NB; i++) pre_cnt[i] <= '0;
    end else begin
      if (accept) begin
        pend_v    <= 1'b1;
        pend_addr <= host_addr;
        pend_we   <= host_we;
      end else if (launch) begin
        pend_v <= 1'b0;
      end

      if (launch) begin
        front_v       <= 1'b1;
        front_ph      <= 1'b0;
        front_bank    <= pb;
        front_addr    <= pend_addr;
        dram_addr     <= pend_addr[2*MUX_W-1:MUX_W];
        dram_ras[pb]  <= 1'b1;
        dram_we[pb]   <= pend_we;
      end else if (front_v && !front_ph) begin
        front_ph             <= 1'b1;
        hcnt                 <= CHW'(T_COLH);
        dram_addr            <= front_addr[MUX_W-1:0];
        dram_cas[front_bank] <= 1'b1;
      end else if (front_v) begin
        if (park_now) begin
          front_v   <= 1'b0;
          park_bank <= front_bank;
          if (pipe_eff)
            dram_addr <= pend_v ? pend_addr[2*MUX_W-1:MUX_W] : front_addr[2*MUX_W-1:MUX_W];
        end else if (hcnt > CHW'(1)) begin
          hcnt <= hcnt - 1'b1;
        end
      end

      if (park_now)     park_v <= 1'b1;
      else if (closing) park_v <= 1'b0;

      if (closing) begin
        dram_ras[park_bank] <= 1'b0;
        dram_cas[park_bank] <= 1'b0;
        dram_we[park_bank]  <= 1'b0;
      end

      for (int i = 0; i < NB; i++) begin
        if (ref_go || (closing && park_bank == BANK_W'(i))) pre_cnt[i] <= PRW'(T_PRE);
        else if (pre_cnt[i] != '0)                          pre_cnt[i] <= pre_cnt[i] - 1'b1;
      end
    end
  end

  AST_CAS_WITH_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_cas & ~dram_ras) == '0); // R2
  AST_NOPIPE_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (park_v && !pipe_eff) |=> (!park_v || $stable(dram_addr))); // R4
  AST_ACK_AFTER_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |-> (dram_cas != '0)); // R10
  AST_ERR_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> !$rose(pend_v)); // R8
  AST_REFRESH_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req |=> ((dram_ras & ~$past(dram_ras)) == '0)); // R7

  for (genvar g = 0; g < NB; g++) begin : g_bank_chk
    AST_PRECHARGE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
      (!dram_ras[g] && pre_cnt[g] != '0) |=> !dram_ras[g]); // R6
  end
endmodule

// File: tb/dram_pipe_ctrl_tb.sv
module dram_pipe_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_pipe = 0, cfg_page = 0, cfg_mode = 0, cfg_wait_en = 1, cfg_ack_en = 1;
  logic host_start = 0, host_cs = 0, host_hold = 0, host_we = 0, refresh_req = 0;
  logic [13:0] host_addr = '0;
  logic host_wait, host_ack, proto_err;
  logic [MW-1:0] dram_addr;
  logic [3:0] dram_ras, dram_cas, dram_we;

  int checks = 0, fails = 0, k = 0;

  dram_pipe_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_pipe(cfg_pipe), .cfg_page(cfg_page), .cfg_mode(cfg_mode),
    .cfg_wait_en(cfg_wait_en), .cfg_ack_en(cfg_ack_en), .host_start(host_start), .host_cs(host_cs),
    .host_hold(host_hold), .host_we(host_we), .host_addr(host_addr), .refresh_req(refresh_req),
    .host_wait(host_wait), .host_ack(host_ack), .proto_err(proto_err), .dram_addr(dram_addr),
    .dram_ras(dram_ras), .dram_cas(dram_cas), .dram_we(dram_we));

  always #(CLK_PERIOD/2) clk = ~clk;

  // row fields: [9]mode [8]pipe [7]page [6]same bank [5]row-on-bus at park [4:0] open edge of 2nd access
  localparam logic [9:0] TAB [7] = '{
    {1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 5'd6},
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd9},
    {1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 5'd9},
    {1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 5'd12},
    {1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 5'd6},
    {1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 5'd12},
    {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'd9}
  };

  localparam logic [1:0]    BA = 2'd1;
  localparam logic [MW-1:0] RA = 6'h15, CA = 6'h2A, RB = 6'h0C, CB = 6'h31;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); k++;
    @(negedge clk);
  endtask

  task automatic do_reset(input logic m, input logic p, input logic pg);
    @(negedge clk);
    rst_n = 0; cfg_mode = m; cfg_pipe = p; cfg_page = pg;
    host_start = 0; host_cs = 1; host_hold = 0; refresh_req = 0; host_addr = '0; host_we = 0;
    repeat (2) @(negedge clk);
    rst_n = 1; k = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset(0, 1, 0);
    chk(dram_ras == 0 && dram_cas == 0 && dram_we == 0, "R1 strobes", dram_ras, 0);
    chk(dram_addr == 0 && !host_wait && !host_ack && !proto_err, "R1 outputs", dram_addr, 0);

    for (int r = 0; r < 7; r++) begin
      logic [1:0] bb;
      int got;
      logic [MW-1:0] exp_addr;
      do_reset(TAB[r][9], TAB[r][8], TAB[r][7]);
      bb = TAB[r][6] ? BA : 2'd2;
      exp_addr = TAB[r][5] ? RB : CA;
      got = -1;
      host_hold = 1; host_start = 1; host_we = 1; host_addr = {BA, RA, CA};
      step();                                   // k=1 accept
      chk(host_wait, "R11 wait on pending", host_wait, 1);
      host_start = 0;
      step();                                   // k=2 open A
      chk(dram_ras[BA] && dram_addr == RA && dram_we[BA], "R2 row phase", dram_addr, RA);
      step();                                   // k=3 column
      chk(dram_cas[BA] && dram_addr == CA, "R2 column phase", dram_addr, CA);
      host_start = 1; host_we = 0; host_addr = {bb, RB, CB};
      step();                                   // k=4 accept B
      host_start = 0;
      step();                                   // k=5 park A
      chk(dram_addr == exp_addr, "R3 R4 bus value at park", dram_addr, exp_addr);
      chk(dram_ras[BA] && dram_cas[BA], "R3 parked strobes held", dram_cas[BA], 1);
      chk(host_ack, "R10 ack while parked", host_ack, 1);
      if (!TAB[r][6] && dram_ras[bb]) got = k;
      step();                                   // k=6
      if (got < 0 && !TAB[r][6] && dram_ras[bb]) got = k;
      step();                                   // k=7
      if (got < 0 && !TAB[r][6] && dram_ras[bb]) got = k;
      host_hold = 0; #1;
      chk(!host_ack, "R10 ack follows hold", host_ack, 0);
      step();                                   // k=8 close A
      chk(TAB[r][6] ? !dram_ras[BA] : (dram_ras[BA] == 1'b0), "R5 close on hold low", dram_ras[BA], 0);
      if (got < 0 && !TAB[r][6] && dram_ras[bb]) got = k;
      for (int c = 9; c <= 16; c++) begin
        step();
        if (got < 0 && dram_ras[bb]) got = k;
      end
      chk(got == int'(TAB[r][4:0]), $sformatf("R3 R4 R6 open edge row %0d", r), got, TAB[r][4:0]);
      repeat (8) step();
      chk(dram_ras == 0, "R5 all closed", dram_ras, 0);
    end

    // R7 refresh holds off a waiting access
    do_reset(0, 1, 0);
    refresh_req = 1; host_hold = 1; host_start = 1; host_addr = {BA, RA, CA};
    step(); host_start = 0;                     // k=1
    step(); refresh_req = 0;                    // k=2
    step(); step(); step();                     // k=5
    chk(!dram_ras[BA] && host_wait, "R7 still precharging", dram_ras[BA], 0);
    step();                                     // k=6
    chk(dram_ras[BA], "R7 open after precharge", dram_ras[BA], 1);

    // R8 early pulse in pulse style
    do_reset(0, 1, 0);
    host_start = 1; host_addr = {BA, RA, CA};
    step(); host_start = 0;                     // k=1
    step();                                     // k=2
    host_start = 1; host_addr = {2'd3, RB, CB}; #1;
    chk(proto_err, "R8 early pulse flagged", proto_err, 1);
    begin
      logic seen = 0;
      for (int c = 0; c < 12; c++) begin step(); host_start = 0; if (dram_ras[3]) seen = 1; end
      chk(!seen, "R8 early pulse ignored", seen, 0);
    end

    // R9 early strobe in level style
    do_reset(1, 1, 0);
    host_hold = 1; host_start = 1; host_addr = {BA, RA, CA};
    step(); host_start = 0;                     // k=1
    step();                                     // k=2
    host_start = 1; host_addr = {2'd3, RB, CB}; #1;
    chk(proto_err, "R9 short negation flagged", proto_err, 1);
    begin
      logic seen = 0;
      for (int c = 0; c < 12; c++) begin step(); if (dram_ras[3]) seen = 1; end
      chk(!seen, "R9 short negation ignored", seen, 0);
    end

    // R12 deselected start
    do_reset(0, 1, 0);
    host_cs = 0; host_start = 1; host_addr = {BA, RA, CA}; #1;
    chk(!proto_err, "R12 no error when deselected", proto_err, 0);
    begin
      logic seen = 0;
      for (int c = 0; c < 6; c++) begin step(); if (dram_ras != 0) seen = 1; end
      chk(!seen, "R12 no strobe when deselected", seen, 0);
    end

    // R10 R11 handshake outputs disabled
    do_reset(0, 1, 0);
    cfg_wait_en = 0; cfg_ack_en = 0;
    host_hold = 1; host_start = 1; host_addr = {BA, RA, CA};
    step(); host_start = 0;
    chk(!host_wait, "R11 wait disabled", host_wait, 0);
    repeat (4) step();
    chk(!host_ack && dram_cas[BA], "R10 ack disabled", host_ack, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule